// File: doc/BRIEF.md
# Shared-Pin Bus Splitter and Command Decoder

This block sits next to a processor that time-shares its pins between address, data and status. A latch-enable strobe tells it which is present. While the strobe is high, the block captures a 20-bit address from the sixteen low shared lines and the four upper shared lines. It captures the bank-high enable with that address. While the strobe is low, the block takes the low lines as data and the upper lines as status.

On the first clock after the strobe falls, the status lines give a segment code and an interrupt-enable copy. Both are held next to the latched address. A split instruction/data memory map can use the segment code to pick one of four banks.

The shared read, write and memory/IO strobes are turned into four separate active-low commands. The block also makes a direction and enable pair for an external data transceiver. Every output is registered and appears one clock after the inputs that cause it.

Top module: `bus_splitter`

## Requirements
- R1: After synchronous reset the outputs read: address 0, bank-high 0, segment 0, interrupt-enable 0, data 0, all four commands 1 (inactive), transceiver direction 0 and transceiver enable 0.
- R2: On each clock edge where the latch enable is 1, the address output becomes {upper lines, low lines}. It holds that value while the latch enable is 0.
- R3: The bank-high output is the inverse of the active-low bank-high input. It is captured on the same edges as the address and held with it.
- R4: On the first edge where the latch enable is 0 after an edge where it was 1, the segment output takes upper lines [1:0] (S4:S3). The codes are 00 extra, 01 stack, 10 code and 11 data. The value is held until the next such edge.
- R5: On the same edges as R4, the interrupt-enable output takes upper line [2] (S5).
- R6: On each edge where the latch enable is 0, the data output takes the low lines. It holds its value while the latch enable is 1.
- R7: One clock after the inputs, exactly one command goes low for each single active strobe. With memory/IO = 1: read low gives memory-read, write low gives memory-write. With memory/IO = 0: read low gives IO-read, write low gives IO-write. At most one command is ever low.
- R8: When read and write are both low, or both high, no command is asserted and the transceiver enable is 0.
- R9: The transceiver direction is 1 only when write alone is active (processor transmits). The transceiver enable is 1 when exactly one of read and write is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch enable strobe |
| ad_lo | input | 16 | Low shared address/data lines |
| ad_hi | input | 4 | Upper shared address/status lines |
| bhe_n | input | 1 | Active-low bank-high enable (shares a pin with S7) |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| mem_io | input | 1 | 1 = memory access, 0 = IO access |
| addr_q | output | 20 | Latched address |
| bank_hi_q | output | 1 | Latched bank-high enable, active high |
| seg_q | output | 2 | Latched segment code |
| ien_q | output | 1 | Latched interrupt-enable status |
| data_q | output | 16 | Data captured from the low lines |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | IO read command, active low |
| io_wr_n | output | 1 | IO write command, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = transmit |
| xcvr_en | output | 1 | Transceiver enable |

## Verification
A stuck or mis-timed address register shows as a wrong `addr_q` on the first edge after the latch enable rises, or as drift while the enable is low. A broken edge detector for status capture moves `seg_q` and `ien_q` in later data-phase cycles, where they should stay frozen. A wrong command decode shows within one clock of any strobe change: either a wrong command line goes low, or two lines go low together, or the transceiver pair disagrees with the strobe.

// File: rtl/bus_splitter_pkg.sv
package bus_splitter_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;

  // command vector order: {io_wr, io_rd, mem_wr, mem_rd}, active low
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_IDLE = '1;
endpackage

// File: rtl/bs_addr_latch.sv
module bs_addr_latch #(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int A_W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  input  logic            bhe_n,
  output logic [A_W-1:0]  addr,
  output logic            bank_hi,
  output logic [LO_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      bank_hi <= 1'b0;
      data    <= '0;
    end else if (ale) begin
      addr    <= {hi, lo};
      bank_hi <= ~bhe_n;
    end else begin
      data    <= lo;
    end
  end
endmodule

// File: rtl/bs_status_cap.sv
module bs_status_cap #(
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [HI_W-1:0] hi,
  output logic [1:0]      seg,
  output logic            ien
);
  logic ale_d;
  logic first_data;

  assign first_data = ale_d & ~ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_d <= 1'b0;
      seg   <= bus_splitter_pkg::SEG_EXTRA;
      ien   <= 1'b0;
    end else begin
      ale_d <= ale;
      if (first_data) begin
        seg <= hi[1:0];
        ien <= hi[2];
      end
    end
  end
endmodule

// File: rtl/bs_cmd_decode.sv
module bs_cmd_decode
  import bus_splitter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             mem_io,
  output logic [CMD_W-1:0] cmd_n,
  output logic             dir,
  output logic             en
);
  logic rd, wr, single;
  logic [CMD_W-1:0] cmd_next;

  assign rd     = ~rd_n;
  assign wr     = ~wr_n;
  assign single = rd ^ wr;

  always_comb begin
    cmd_next = CMD_IDLE;
    if (single) begin
      unique case ({mem_io, wr})
        2'b10:   cmd_next[0] = 1'b0;
        2'b11:   cmd_next[1] = 1'b0;
        2'b00:   cmd_next[2] = 1'b0;
        default: cmd_next[3] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_n <= CMD_IDLE;
      dir   <= 1'b0;
      en    <= 1'b0;
    end else begin
      cmd_n <= cmd_next;
      dir   <= wr & ~rd;
      en    <= single;
    end
  end
endmodule

// File: rtl/bus_splitter.sv
module bus_splitter #(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int A_W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_lo,
  input  logic [HI_W-1:0] ad_hi,
  input  logic            bhe_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            mem_io,
  output logic [A_W-1:0]  addr_q,
  output logic            bank_hi_q,
  output logic [1:0]      seg_q,
  output logic            ien_q,
  output logic [LO_W-1:0] data_q,
  output logic            mem_rd_n,
  output logic            mem_wr_n,
  output logic            io_rd_n,
  output logic            io_wr_n,
  output logic            xcvr_dir,
  output logic            xcvr_en
);
  logic [bus_splitter_pkg::CMD_W-1:0] cmd_n;

  bs_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .lo(ad_lo), .hi(ad_hi),
    .bhe_n(bhe_n), .addr(addr_q), .bank_hi(bank_hi_q), .data(data_q)
  );

  bs_status_cap #(.HI_W(HI_W)) u_status (
    .clk(clk), .rst(rst), .ale(ale), .hi(ad_hi),
    .seg(seg_q), .ien(ien_q)
  );

  bs_cmd_decode u_cmd (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .mem_io(mem_io),
    .cmd_n(cmd_n), .dir(xcvr_dir), .en(xcvr_en)
  );

  assign mem_rd_n = cmd_n[0];
  assign mem_wr_n = cmd_n[1];
  assign io_rd_n  = cmd_n[2];
  assign io_wr_n  = cmd_n[3];
endmodule

// File: rtl/bus_splitter_chk.sv
module bus_splitter_chk #(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int A_W = LO_W + HI_W
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic [LO_W-1:0] ad_lo,
  input logic [HI_W-1:0] ad_hi,
  input logic            bhe_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic            mem_io,
  input logic [A_W-1:0]  addr_q,
  input logic            bank_hi_q,
  input logic [1:0]      seg_q,
  input logic            ien_q,
  input logic [LO_W-1:0] data_q,
  input logic            mem_rd_n,
  input logic            mem_wr_n,
  input logic            io_rd_n,
  input logic            io_wr_n,
  input logic            xcvr_dir,
  input logic            xcvr_en
);
  // R2
  addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ale) && !$past(rst)) |-> addr_q == $past({ad_hi, ad_lo}));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ale) && !$past(rst)) |-> $stable(addr_q));
  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ale) && !$past(rst)) |-> $stable(bank_hi_q));
  // R4
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ale) && !$past(ale, 2) && !$past(rst) && !$past(rst, 2)) |-> $stable(seg_q));
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ale) && !$past(rst)) |-> $stable(data_q));
  // R7
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}));
  // R8
  both_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !wr_n) |=> ({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF && !xcvr_en));
  // R9
  xcvr_en_chk: assert property (@(posedge clk) disable iff (rst)
    xcvr_en == ($countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) == 1));
  // R9
  xcvr_dir_chk: assert property (@(posedge clk) disable iff (rst)
    xcvr_dir |-> (!mem_wr_n || !io_wr_n));
endmodule

bind bus_splitter bus_splitter_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/bus_splitter_test.sv
`timescale 1ns/1ps
module bus_splitter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0;
  logic [15:0] ad_lo = '0;
  logic [3:0]  ad_hi = '0;
  logic bhe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mem_io = 1'b0;
  logic [19:0] addr_q;
  logic bank_hi_q, ien_q;
  logic [1:0] seg_q;
  logic [15:0] data_q;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, xcvr_dir, xcvr_en;

  int checks = 0;
  int fails  = 0;

  // expected state built from the requirements
  logic [19:0] e_addr = '0;
  logic        e_bhi = 1'b0, e_ien = 1'b0, prev_ale = 1'b0;
  logic [1:0]  e_seg = '0;
  logic [15:0] e_data = '0;

  always #5 clk = ~clk;

  bus_splitter uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input logic r_n, input logic w_n, input logic mio);
    logic r, w;
    r = ~r_n; w = ~w_n;
    exp_cmd = 4'hF; // {io_wr, io_rd, mem_wr, mem_rd}
    if (r ^ w) begin
      if (mio && r)  exp_cmd[0] = 1'b0;
      if (mio && w)  exp_cmd[1] = 1'b0;
      if (!mio && r) exp_cmd[2] = 1'b0;
      if (!mio && w) exp_cmd[3] = 1'b0;
    end
  endfunction

  task automatic step(input logic a, input logic [15:0] lo, input logic [3:0] hi,
                      input logic bh, input logic r, input logic w, input logic mio);
    logic [3:0] ec;
    @(negedge clk);
    ale = a; ad_lo = lo; ad_hi = hi; bhe_n = bh; rd_n = r; wr_n = w; mem_io = mio;
    if (a) begin e_addr = {hi, lo}; e_bhi = ~bh; end
    else   e_data = lo;
    if (prev_ale && !a) begin e_seg = hi[1:0]; e_ien = hi[2]; end
    prev_ale = a;
    ec = exp_cmd(r, w, mio);
    @(posedge clk); #1;
    chk("R2 addr", addr_q, e_addr);
    chk("R3 bank_hi", bank_hi_q, e_bhi);
    chk("R4 seg", seg_q, e_seg);
    chk("R5 ien", ien_q, e_ien);
    chk("R6 data", data_q, e_data);
    chk("R7 cmd", {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n}, ec);
    chk("R8 R9 xcvr_en", xcvr_en, (~r) ^ (~w));
    chk("R9 xcvr_dir", xcvr_dir, (~w) & r);
  endtask

  task automatic bus_cycle(input logic [19:0] a, input logic bh, input logic [1:0] sg,
                           input logic ie, input logic mio, input logic is_wr,
                           input logic [15:0] d, input int waits);
    step(1'b1, a[15:0], a[19:16], bh, 1'b1, 1'b1, mio);              // T1
    step(1'b0, d, {1'b0, ie, sg}, bh, is_wr, ~is_wr, mio);            // T2
    for (int i = 0; i < waits; i++)
      step(1'b0, d ^ 16'h00FF, {1'b0, ~ie, ~sg}, bh, is_wr, ~is_wr, mio); // T3/Tw, status must not re-latch
    step(1'b0, d, {1'b0, ie, sg}, bh, 1'b1, 1'b1, mio);               // T4
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 addr", addr_q, 0);
    chk("R1 bank_hi", bank_hi_q, 0);
    chk("R1 seg", seg_q, 0);
    chk("R1 ien", ien_q, 0);
    chk("R1 data", data_q, 0);
    chk("R1 cmd", {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n}, 4'hF);
    chk("R1 xcvr", {xcvr_dir, xcvr_en}, 0);
    @(negedge clk); rst = 1'b0;

    // directed: each segment code, each command
    bus_cycle(20'hFFFF0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 16'h1234, 0); // R4 code, R7 mem read
    bus_cycle(20'h12345, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 16'hBEEF, 1); // R4 data, R7 mem write
    bus_cycle(20'h00080, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 16'h5A5A, 2); // R4 stack, R7 io read
    bus_cycle(20'h003F8, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 16'hA5A5, 0); // R4 extra, R7 io write
    // R8: both strobes low, then both high
    step(1'b0, 16'h0F0F, 4'h3, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 16'h0F0E, 4'h3, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 16'h0F0D, 4'h3, 1'b0, 1'b1, 1'b1, 1'b1);
    // R2/R3: long ALE high, address tracks each cycle
    step(1'b1, 16'h1111, 4'h1, 1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b1, 16'h2222, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 16'h3333, 4'h7, 1'b0, 1'b1, 1'b1, 1'b1);

    // constrained random bus cycles
    for (int n = 0; n < 400; n++) begin
      bus_cycle($urandom() & 20'hFFFFF, 1'($urandom()), 2'($urandom()), 1'($urandom()),
                1'($urandom()), 1'($urandom()), 16'($urandom()), int'($urandom_range(0, 3)));
      if (($urandom() & 15) == 0)
        step(1'b0, 16'($urandom()), 4'($urandom()), 1'($urandom()), 1'b0, 1'b0, 1'($urandom())); // R8
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule